// File: doc/BRIEF.md
# Multiplexed-Address DRAM Grid Model

This block is a synthesizable behavioural model of a small dynamic memory. It stores ROWS x COLS supercells of WIDTH bits each. A single narrow address port carries a row index with the row strobe and a column index with the column strobe. A row strobe opens a row by copying all of it into an internal row buffer. A later column strobe either returns one supercell of that buffer on the read data port, or changes it when the write enable is set. The buffer goes back into the array when the row is closed, or when a row strobe opens a different row.

A refresh request rewrites one row from its own contents. Rows are visited in rotating order. If a row is open when a request arrives, the request is held until the row is closed. Each completed refresh is reported with a one-cycle acknowledge that carries the row index. A column strobe given while no row is open does nothing and raises an error flag for one cycle.

Top module: `dram_grid`

## Requirements
- R1: While rst_n is low at a clock edge, the model returns to this state after that edge: no row open, all cells zero, rdata_vld, col_err and refresh_ack low, and the refresh pointer at row 0.
- R2: A row strobe opens the row named by the low log2(ROWS) bits of addr at that edge. The row stays open until close_row or another row strobe.
- R3: A column strobe with wr_en low, on an open row, makes rdata equal the buffered supercell at column addr (its low log2(COLS) bits) and sets rdata_vld. Both take effect one clock later.
- R4: rdata and rdata_vld hold their values until the next column strobe, row strobe or close_row. A write column strobe clears rdata_vld.
- R5: A column strobe with wr_en high, on an open row, replaces the buffered supercell at the selected column with wdata. A later read of that row returns the new value.
- R6: The buffer is written back to its array row when close_row is given or when a row strobe opens a different row. close_row leaves no row open and rdata_vld low.
- R7: A column strobe with no open row, and with no row strobe or close_row in the same cycle, changes no stored data and no output except col_err. col_err is high for the one cycle after that strobe.
- R8: A refresh request made while no row is open, and with no row strobe in the same cycle, is served at that edge. refresh_ack is high for the next cycle and refresh_row shows the served row. Pointers run 0, 1, ... ROWS-1 and wrap. Stored data does not change.
- R9: Refresh requests that arrive while a row is open are counted, up to 2^PEND_W-1 of them. They are served one per cycle starting at the edge after the row closes, so no acknowledge follows a cycle in which a row was open.
- R10: When strobes arrive in the same cycle, the row strobe comes first, then close_row, then the column strobe. A column strobe that loses to another strobe is dropped without an error. A row strobe that reopens the row already open keeps the buffer contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW | Shared row/column index |
| row_stb | input | 1 | Open the row named on addr |
| col_stb | input | 1 | Access the column named on addr in the open row |
| close_row | input | 1 | Write back and close the open row |
| wr_en | input | 1 | With col_stb: write instead of read |
| wdata | input | WIDTH | Write data |
| refresh_req | input | 1 | Request one row refresh |
| rdata | output | WIDTH | Read data |
| rdata_vld | output | 1 | rdata holds a valid read result |
| col_err | output | 1 | Column strobe with no open row (one cycle) |
| refresh_ack | output | 1 | A row was refreshed (one cycle) |
| refresh_row | output | log2(ROWS) | Row just refreshed |

## Verification
The bench builds the model with its defaults: 4 rows, 4 columns, 8-bit cells and a 2-bit pending refresh counter. The grid has only 16 cells, so every one of them can be written with a different value and then read back through the buffer. The 4-entry rotation is small enough that the refresh pointer can be followed from row 0 in one test, including deferred requests that are served back to back after a close. With row and column indices of equal width, a single address value covers both halves of a strobe collision, so the priority cases run with the same addr.

// File: rtl/dram_grid_pkg.sv
// Package: types shared by the DRAM grid model.
// Assumes: nothing beyond standard SystemVerilog.
package dram_grid_pkg;

    // Which source owns the single array write port in a cycle.
    typedef enum logic [1:0] {
        WP_IDLE    = 2'd0,
        WP_BACK    = 2'd1,
        WP_REFRESH = 2'd2
    } wport_sel_e;

endpackage

// File: rtl/dram_cell_array.sv
// Module: dram_cell_array
// Storage grid of ROWS rows. One row-wide write port and two combinational
// row read ports: port A feeds the row buffer, port B feeds refresh.
// Assumes: at most one row write per cycle; contents clear on reset.
module dram_cell_array #(
    parameter int ROWS  = 4,
    parameter int COLS  = 4,
    parameter int WIDTH = 8,
    localparam int RA   = $clog2(ROWS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [RA-1:0]               wr_row,
    input  logic [COLS-1:0][WIDTH-1:0]  wr_data,
    input  logic [RA-1:0]               rd_a_row,
    output logic [COLS-1:0][WIDTH-1:0]  rd_a_data,
    input  logic [RA-1:0]               rd_b_row,
    output logic [COLS-1:0][WIDTH-1:0]  rd_b_data
);

    logic [COLS-1:0][WIDTH-1:0] mem_q [ROWS];

    // Row storage: clear on reset, otherwise take one full-row write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                mem_q[r] <= '0;
            end
        end else if (wr_en) begin
            mem_q[wr_row] <= wr_data;
        end
    end

    // Two independent combinational row reads.
    always_comb begin
        rd_a_data = mem_q[rd_a_row];
        rd_b_data = mem_q[rd_b_row];
    end

endmodule

// File: rtl/dram_row_buffer.sv
// Module: dram_row_buffer
// Holds the open row and serves column reads and writes. The registered
// read result stays put until a new access or a clear.
// Assumes: load, cell_rd and cell_we are mutually exclusive (the caller
// decides priority); clear_rd may coincide with load.
module dram_row_buffer #(
    parameter int COLS  = 4,
    parameter int WIDTH = 8,
    localparam int CA   = $clog2(COLS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [COLS-1:0][WIDTH-1:0]  load_data,
    input  logic                        cell_rd,
    input  logic                        cell_we,
    input  logic [CA-1:0]               col,
    input  logic [WIDTH-1:0]            wdata,
    input  logic                        clear_rd,
    output logic [COLS-1:0][WIDTH-1:0]  row_q,
    output logic [WIDTH-1:0]            rdata,
    output logic                        rdata_vld
);

    // Buffer contents: whole-row load or a single-cell update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (load) begin
            row_q <= load_data;
        end else if (cell_we) begin
            row_q[col] <= wdata;
        end
    end

    // Read result register and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata     <= '0;
            rdata_vld <= 1'b0;
        end else if (clear_rd) begin
            rdata_vld <= 1'b0;
        end else if (cell_rd) begin
            rdata     <= row_q[col];
            rdata_vld <= 1'b1;
        end else if (cell_we) begin
            rdata_vld <= 1'b0;
        end
    end

endmodule

// File: rtl/dram_refresh_ctrl.sv
// Module: dram_refresh_ctrl
// Counts refresh requests, serves one per cycle while allowed, walks a
// rotating row pointer and reports each served row for one cycle.
// Assumes: the pending count saturates at 2^PEND_W-1; extra requests drop.
module dram_refresh_ctrl #(
    parameter int ROWS   = 4,
    parameter int PEND_W = 2,
    localparam int RA    = $clog2(ROWS),
    localparam int PMAX  = (1 << PEND_W) - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          allow,
    output logic          svc,
    output logic [RA-1:0] svc_row,
    output logic          ack,
    output logic [RA-1:0] ack_row
);

    logic [PEND_W-1:0] pend_q;
    logic [PEND_W:0]   pend_sum;

    // Serve when something is waiting and the array port is free.
    always_comb begin
        svc      = allow && (req || (pend_q != '0));
        pend_sum = {1'b0, pend_q} + {{PEND_W{1'b0}}, req}
                 - {{PEND_W{1'b0}}, svc};
    end

    // Pending count with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (pend_sum > (PEND_W+1)'(PMAX)) begin
            pend_q <= PEND_W'(PMAX);
        end else begin
            pend_q <= pend_sum[PEND_W-1:0];
        end
    end

    // Rotating row pointer and one-cycle acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_row <= '0;
            ack     <= 1'b0;
            ack_row <= '0;
        end else begin
            ack <= svc;
            if (svc) begin
                ack_row <= svc_row;
                svc_row <= (svc_row == RA'(ROWS-1)) ? '0 : svc_row + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dram_grid.sv
// Module: dram_grid (top)
// Multiplexed-address DRAM grid: row strobe opens a row into the buffer,
// column strobe reads or writes one cell, close or a new row writes back,
// refresh rewrites rows in rotation only while no row is open.
// Assumes: ROWS and COLS are powers of two, each at least 2. Strobe
// priority is row_stb, then close_row, then col_stb.
module dram_grid #(
    parameter int ROWS   = 4,
    parameter int COLS   = 4,
    parameter int WIDTH  = 8,
    parameter int PEND_W = 2,
    localparam int RA    = $clog2(ROWS),
    localparam int CA    = $clog2(COLS),
    localparam int AW    = (RA > CA) ? RA : CA
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             row_stb,
    input  logic             col_stb,
    input  logic             close_row,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wdata,
    input  logic             refresh_req,
    output logic [WIDTH-1:0] rdata,
    output logic             rdata_vld,
    output logic             col_err,
    output logic [RA-1:0]    refresh_row
    ,output logic            refresh_ack
);
    import dram_grid_pkg::*;

    logic                       row_open;
    logic [RA-1:0]              open_row;
    logic [RA-1:0]              row_a;
    logic [CA-1:0]              col_a;
    logic                       same_row, col_ok, col_bad;
    logic                       buf_load, cell_rd, cell_we, clear_rd;
    logic                       ref_allow, ref_svc;
    logic [RA-1:0]              ref_row;
    logic [COLS-1:0][WIDTH-1:0] buf_row, arr_a, arr_b, wp_data;
    logic [RA-1:0]              wp_row;
    wport_sel_e                 wp_sel;

    // Decode strobes by priority into buffer, array and refresh actions.
    always_comb begin
        row_a     = addr[RA-1:0];
        col_a     = addr[CA-1:0];
        same_row  = row_open && (row_a == open_row);
        col_ok    = col_stb && !row_stb && !close_row && row_open;
        col_bad   = col_stb && !row_stb && !close_row && !row_open;
        buf_load  = row_stb && !same_row;
        cell_rd   = col_ok && !wr_en;
        cell_we   = col_ok && wr_en;
        clear_rd  = row_stb || close_row;
        ref_allow = !row_open && !row_stb;
    end

    // Pick the owner of the array write port.
    always_comb begin
        wp_sel  = WP_IDLE;
        wp_row  = open_row;
        wp_data = buf_row;
        if (row_open && ((row_stb && !same_row) || (close_row && !row_stb))) begin
            wp_sel = WP_BACK;
        end else if (ref_svc) begin
            wp_sel  = WP_REFRESH;
            wp_row  = ref_row;
            wp_data = arr_b;
        end
    end

    // Open-row state and the one-cycle column error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_open <= 1'b0;
            open_row <= '0;
            col_err  <= 1'b0;
        end else begin
            col_err <= col_bad;
            if (row_stb) begin
                row_open <= 1'b1;
                open_row <= row_a;
            end else if (close_row) begin
                row_open <= 1'b0;
            end
        end
    end

    dram_cell_array #(.ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH)) array_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wp_sel != WP_IDLE),
        .wr_row    (wp_row),
        .wr_data   (wp_data),
        .rd_a_row  (row_a),
        .rd_a_data (arr_a),
        .rd_b_row  (ref_row),
        .rd_b_data (arr_b)
    );

    dram_row_buffer #(.COLS(COLS), .WIDTH(WIDTH)) rowbuf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (buf_load),
        .load_data (arr_a),
        .cell_rd   (cell_rd),
        .cell_we   (cell_we),
        .col       (col_a),
        .wdata     (wdata),
        .clear_rd  (clear_rd),
        .row_q     (buf_row),
        .rdata     (rdata),
        .rdata_vld (rdata_vld)
    );

    dram_refresh_ctrl #(.ROWS(ROWS), .PEND_W(PEND_W)) refresh_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (refresh_req),
        .allow   (ref_allow),
        .svc     (ref_svc),
        .svc_row (ref_row),
        .ack     (refresh_ack),
        .ack_row (refresh_row)
    );

endmodule

// File: rtl/dram_grid_chk.sv
// Module: dram_grid_chk
// Temporal checks on the DRAM grid ports and its open-row state.
// Assumes: bound to dram_grid; reset is held for at least one edge.
module dram_grid_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             row_stb,
    input logic             col_stb,
    input logic             close_row,
    input logic             wr_en,
    input logic [WIDTH-1:0] rdata,
    input logic             rdata_vld,
    input logic             col_err,
    input logic             refresh_ack,
    input logic             row_open
);

    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (col_stb && !wr_en && !row_stb && !close_row && row_open) |=> rdata_vld); // R3

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_vld && !col_stb && !row_stb && !close_row) |=> (rdata_vld && $stable(rdata))); // R4

    AST_WRITE_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (col_stb && wr_en && !row_stb && !close_row && row_open) |=> !rdata_vld); // R4

    AST_CLOSE_SHUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (close_row && !row_stb) |=> (!row_open && !rdata_vld)); // R6

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        col_err |-> $past(col_stb && !row_stb && !close_row && !row_open)); // R7

    AST_REFRESH_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_ack |-> !$past(row_open)); // R9

endmodule

bind dram_grid dram_grid_chk #(.WIDTH(WIDTH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .row_stb     (row_stb),
    .col_stb     (col_stb),
    .close_row   (close_row),
    .wr_en       (wr_en),
    .rdata       (rdata),
    .rdata_vld   (rdata_vld),
    .col_err     (col_err),
    .refresh_ack (refresh_ack),
    .row_open    (row_open)
);

// File: tb/dram_grid_tb_top.sv
// Bench: scoreboard for dram_grid. Driver tasks push expected read data
// into a queue; a monitor pops and compares one clock after each read.
module dram_grid_tb_top;
    localparam int CLK_NS = 10;
    localparam int ROWS   = 4;
    localparam int COLS   = 4;
    localparam int WIDTH  = 8;
    localparam int AW     = 2;
    localparam int RA     = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [AW-1:0]    addr = '0;
    logic             row_stb = 1'b0, col_stb = 1'b0, close_row = 1'b0;
    logic             wr_en = 1'b0, refresh_req = 1'b0;
    logic [WIDTH-1:0] wdata = '0;
    logic [WIDTH-1:0] rdata;
    logic             rdata_vld, col_err, refresh_ack;
    logic [RA-1:0]    refresh_row;

    always #(CLK_NS/2) clk = ~clk;

    dram_grid #(.ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH), .PEND_W(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .row_stb(row_stb),
        .col_stb(col_stb), .close_row(close_row), .wr_en(wr_en),
        .wdata(wdata), .refresh_req(refresh_req), .rdata(rdata),
        .rdata_vld(rdata_vld), .col_err(col_err),
        .refresh_row(refresh_row), .refresh_ack(refresh_ack)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [WIDTH-1:0] model [ROWS][COLS];
    bit   m_open = 1'b0;
    int   m_row = 0;
    logic [WIDTH-1:0] exp_q [$];
    string tag_q [$];
    bit   rd_pending = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: note a read issued at this edge, compare it one clock later.
    always @(posedge clk) begin
        rd_pending <= rst_n && col_stb && !wr_en && !row_stb && !close_row && m_open;
    end

    always @(negedge clk) begin
        if (rd_pending) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected read", int'(rdata), 0);
            end else begin
                logic [WIDTH-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rdata_vld == 1'b1, t, int'(rdata_vld), 1);
                chk(rdata == e, t, int'(rdata), int'(e));
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic open_row(input int r);
        row_stb = 1'b1; addr = AW'(r);
        step();
        row_stb = 1'b0;
        m_open = 1'b1; m_row = r;
    endtask

    task automatic shut_row();
        close_row = 1'b1;
        step();
        close_row = 1'b0;
        m_open = 1'b0;
    endtask

    task automatic wr_cell(input int c, input logic [WIDTH-1:0] d);
        col_stb = 1'b1; wr_en = 1'b1; addr = AW'(c); wdata = d;
        step();
        col_stb = 1'b0; wr_en = 1'b0;
        model[m_row][c] = d;
    endtask

    task automatic rd_cell(input int c, input string tag);
        exp_q.push_back(model[m_row][c]);
        tag_q.push_back(tag);
        col_stb = 1'b1; addr = AW'(c);
        step();
        col_stb = 1'b0;
    endtask

    task automatic pulse_refresh();
        refresh_req = 1'b1;
        step();
        refresh_req = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                model[r][c] = '0;

        // R1: reset state
        repeat (4) step();
        rst_n = 1'b1;
        step();
        chk(rdata_vld == 1'b0, "R1 rdata_vld", int'(rdata_vld), 0);
        chk(col_err == 1'b0, "R1 col_err", int'(col_err), 0);
        chk(refresh_ack == 1'b0, "R1 refresh_ack", int'(refresh_ack), 0);
        open_row(2);
        rd_cell(3, "R1 cleared cell");
        shut_row();

        // R5, R2: fill every cell with a distinct value, close each row
        for (int r = 0; r < ROWS; r++) begin
            open_row(r);
            for (int c = 0; c < COLS; c++) wr_cell(c, WIDTH'(8'h30 + r*COLS + c));
            shut_row();
            chk(rdata_vld == 1'b0, "R6 close drops valid", int'(rdata_vld), 0);
        end

        // R3, R6: read everything back after write-back on close
        for (int r = 0; r < ROWS; r++) begin
            open_row(r);
            for (int c = COLS-1; c >= 0; c--) rd_cell(c, "R3 readback");
            shut_row();
        end

        // R4: hold, then write clears valid, then read the new value (R5)
        open_row(1);
        rd_cell(2, "R4 first read");
        for (int i = 0; i < 3; i++) begin
            step();
            chk(rdata_vld == 1'b1 && rdata == model[1][2], "R4 hold", int'(rdata), int'(model[1][2]));
        end
        wr_cell(2, 8'hA7);
        chk(rdata_vld == 1'b0, "R4 write clears valid", int'(rdata_vld), 0);
        rd_cell(2, "R5 updated cell");
        shut_row();
        chk(rdata_vld == 1'b0, "R4 close clears valid", int'(rdata_vld), 0);

        // R6: write-back when a row strobe opens a different row
        open_row(3);
        wr_cell(0, 8'h5A);
        open_row(0);
        rd_cell(0, "R6 other row intact");
        open_row(3);
        rd_cell(0, "R6 writeback on new row");

        // R10: reopening the open row keeps buffered writes
        wr_cell(1, 8'hC3);
        open_row(3);
        rd_cell(1, "R10 same-row reopen");
        shut_row();

        // R7: column strobe with no open row
        col_stb = 1'b1; wr_en = 1'b1; addr = 2'd0; wdata = 8'hFF;
        step();
        col_stb = 1'b0; wr_en = 1'b0;
        chk(col_err == 1'b1, "R7 error raised", int'(col_err), 1);
        chk(rdata_vld == 1'b0, "R7 no read", int'(rdata_vld), 0);
        step();
        chk(col_err == 1'b0, "R7 error one cycle", int'(col_err), 0);

        // R10: close_row beats a column write in the same cycle
        open_row(2);
        close_row = 1'b1; col_stb = 1'b1; wr_en = 1'b1; addr = 2'd0; wdata = 8'hFF;
        step();
        close_row = 1'b0; col_stb = 1'b0; wr_en = 1'b0;
        m_open = 1'b0;
        chk(col_err == 1'b0, "R10 no error on close+col", int'(col_err), 0);
        // R10: row strobe beats a column write in the same cycle
        open_row(2);
        rd_cell(0, "R10 close dropped write");
        row_stb = 1'b1; col_stb = 1'b1; wr_en = 1'b1; addr = 2'd1; wdata = 8'hEE;
        step();
        row_stb = 1'b0; col_stb = 1'b0; wr_en = 1'b0;
        m_row = 1;
        chk(col_err == 1'b0, "R10 no error on row+col", int'(col_err), 0);
        rd_cell(1, "R10 row strobe dropped write");
        shut_row();

        // R8: refresh while idle is served at once, pointer starts at 0
        pulse_refresh();
        chk(refresh_ack == 1'b1, "R8 ack", int'(refresh_ack), 1);
        chk(refresh_row == 2'd0, "R8 first row", int'(refresh_row), 0);
        step();
        chk(refresh_ack == 1'b0, "R8 ack one cycle", int'(refresh_ack), 0);

        // R9: refresh deferred while a row is open, served after close
        open_row(2);
        pulse_refresh();
        chk(refresh_ack == 1'b0, "R9 deferred", int'(refresh_ack), 0);
        pulse_refresh();
        chk(refresh_ack == 1'b0, "R9 deferred", int'(refresh_ack), 0);
        shut_row();
        chk(refresh_ack == 1'b0, "R9 not on close edge", int'(refresh_ack), 0);
        step();
        chk(refresh_ack == 1'b1 && refresh_row == 2'd1, "R9 first deferred", int'(refresh_row), 1);
        step();
        chk(refresh_ack == 1'b1 && refresh_row == 2'd2, "R9 second deferred", int'(refresh_row), 2);
        step();
        chk(refresh_ack == 1'b0, "R9 queue drained", int'(refresh_ack), 0);

        // R8: refreshed rows keep their data
        for (int r = 0; r < 3; r++) begin
            open_row(r);
            for (int c = 0; c < COLS; c++) rd_cell(c, "R8 data kept");
            shut_row();
        end

        step();
        chk(exp_q.size() == 0, "R3 all reads seen", exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule